// File: doc/BRIEF.md
# Programmable Up/Down Timer Counter

This block is the counting core of a general-purpose 8-bit timer. It advances its count once per qualified timer tick. A tick is qualified when the tick strobe is high and the clock-select field is non-zero. A 3-bit waveform-mode input chooses the count sequence:

- a free-running wrap;
- a clear on reaching compare register A;
- a single-slope PWM ramp;
- a dual-slope ramp that climbs to TOP and falls back to zero.

In these sequences BOTTOM is the count 0x00 and MAX is 0xFF. TOP is either MAX or the compare-A value, depending on the mode. The block raises an overflow flag at a point in the sequence that depends on the mode. It also drives combinational indications for TOP, BOTTOM and the current counting direction.

Software reaches the block through a small register port with one address bit. Address 0 holds the count and can be read or written at any time, whether or not ticks arrive. Address 1 holds the overflow flag in bit 0. Writing a one to that bit clears the flag. An interrupt-acknowledge pulse also clears the flag. A write to the count always wins over the tick arriving in the same cycle.

Mode codes: 0 normal, 1 dual-slope with TOP=0xFF, 2 clear-on-match, 3 single-slope with TOP=0xFF, 5 dual-slope with TOP=compare A, 7 single-slope with TOP=compare A. Codes 4 and 6 behave as normal.

Top module: `updn_timer`

## Requirements
- R1: After reset the count is 0x00, the overflow flag is 0 and the direction output (countDown) is 0.
- R2: When tick is low or clkSel is 0, the count holds its value.
- R3: In mode 0, and in the unused codes 4 and 6, each qualified tick adds one to the count. The count wraps from 0xFF to 0x00, and the overflow flag is set on the tick that performs that wrap.
- R4: In mode 2, a qualified tick with count equal to compare A loads 0x00; otherwise the tick adds one. The overflow flag is set on a tick taken at count 0xFF.
- R5: In modes 3 (TOP=0xFF) and 7 (TOP=compare A), a qualified tick at TOP loads 0x00 and sets the overflow flag; otherwise the tick adds one.
- R6: In modes 1 (TOP=0xFF) and 5 (TOP=compare A), the count rises. A tick taken at or above TOP while rising turns the direction down and subtracts one. A tick taken at 0x00 while falling turns the direction up and adds one. countDown is 1 while falling.
- R7: In modes 1 and 5, the overflow flag is set on the falling tick that moves the count from 0x01 to 0x00.
- R8: A write to address 0 loads the write data into the count. Any tick in the same cycle has no effect: no count change and no flag set.
- R9: Writing address 1 with bit 0 = 1, or pulsing ovfAck, clears the flag. Writing bit 0 = 0 leaves it unchanged. A flag set in the same cycle as a clear wins.
- R10: regRdData returns the count for address 0, and {7'b0, flag} for address 1.
- R11: atBottom is 1 exactly when the count is 0x00. atTop is 1 exactly when the count equals the TOP of the current mode.
- R12: A qualified tick in any mode other than 1 or 5 forces the direction to up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer tick strobe |
| clkSel | input | 3 | Clock-select field; 0 stops counting |
| waveMode | input | 3 | Count-sequence mode code |
| cmpA | input | 8 | Compare register A value |
| ovfAck | input | 1 | Interrupt-acknowledge pulse, clears the flag |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = count, 1 = status |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| count | output | 8 | Current count |
| countDown | output | 1 | 1 while counting down |
| atTop | output | 1 | Count equals TOP |
| atBottom | output | 1 | Count equals 0x00 |
| ovfFlag | output | 1 | Overflow flag |

## Verification
A wrong count or direction state shows on the count port at the very next qualified tick. It appears as a value off by one, a missed clear, or a wrong turnaround in the dual-slope modes.

A wrong flag decision appears on ovfFlag one clock after the tick that should, or should not, have set it. The error persists until a clear, so sampling after short tick bursts localizes it.

Write-priority errors appear one clock after a write collides with a tick, as either a stray increment or a stray flag.

// File: rtl/updn_tmr_pkg.sv
package updn_tmr_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_NORMAL   = 3'd0,
    MODE_DUAL_MAX = 3'd1,
    MODE_CLR_CMP  = 3'd2,
    MODE_RAMP_MAX = 3'd3,
    MODE_RSV4     = 3'd4,
    MODE_DUAL_CMP = 3'd5,
    MODE_RSV6     = 3'd6,
    MODE_RAMP_CMP = 3'd7
  } waveMode_e;

  typedef struct packed {
    logic loadCnt;
    logic clrCnt;
    logic incCnt;
    logic decCnt;
    logic goDown;
    logic goUp;
    logic setOvf;
    logic clrOvf;
  } tmrStrobe_t;

  function automatic logic isDual(input logic [MODE_W-1:0] m);
    return (m == MODE_DUAL_MAX) || (m == MODE_DUAL_CMP);
  endfunction

  function automatic logic isRamp(input logic [MODE_W-1:0] m);
    return (m == MODE_RAMP_MAX) || (m == MODE_RAMP_CMP);
  endfunction

  function automatic logic usesCmpTop(input logic [MODE_W-1:0] m);
    return (m == MODE_CLR_CMP) || (m == MODE_DUAL_CMP) || (m == MODE_RAMP_CMP);
  endfunction

endpackage

// File: rtl/updn_tmr_ctrl.sv
module updn_tmr_ctrl
  import updn_tmr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              tick,
  input  logic [2:0]        clkSel,
  input  logic [MODE_W-1:0] waveMode,
  input  logic [WIDTH-1:0]  cmpA,
  input  logic              ovfAck,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [WIDTH-1:0]  regWrData,
  input  logic [WIDTH-1:0]  cntQ,
  input  logic              downQ,
  output logic [WIDTH-1:0]  topVal,
  output tmrStrobe_t        stb
);

  localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic tickOk;
  logic wrCnt;
  logic wrStat;
  logic runTick;

  assign tickOk  = tick && (clkSel != 3'd0);
  assign wrCnt   = regWrEn && (regAddr == 1'b0);
  assign wrStat  = regWrEn && (regAddr == 1'b1);
  assign runTick = tickOk && !wrCnt;
  assign topVal  = usesCmpTop(waveMode) ? cmpA : MAXV;

  always_comb begin
    stb = '0;
    stb.loadCnt = wrCnt;
    stb.clrOvf  = (wrStat && regWrData[0]) || ovfAck;
    if (runTick) begin
      if (isDual(waveMode)) begin
        if (!downQ) begin
          if (cntQ >= topVal) begin
            stb.goDown = 1'b1;
            stb.decCnt = (cntQ != ZERO);
          end else begin
            stb.incCnt = 1'b1;
          end
        end else begin
          if (cntQ == ZERO) begin
            stb.goUp   = 1'b1;
            stb.incCnt = (topVal != ZERO);
          end else begin
            stb.decCnt = 1'b1;
            stb.setOvf = (cntQ == ONE);
          end
        end
      end else begin
        stb.goUp = downQ;
        if (isRamp(waveMode)) begin
          if (cntQ == topVal) begin
            stb.clrCnt = 1'b1;
            stb.setOvf = 1'b1;
          end else begin
            stb.incCnt = 1'b1;
          end
        end else if (waveMode == MODE_CLR_CMP) begin
          stb.clrCnt = (cntQ == topVal);
          stb.incCnt = (cntQ != topVal);
          stb.setOvf = (cntQ == MAXV);
        end else begin
          stb.incCnt = 1'b1;
          stb.setOvf = (cntQ == MAXV);
        end
      end
    end
  end

endmodule

// File: rtl/updn_tmr_dpath.sv
module updn_tmr_dpath
  import updn_tmr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       stb,
  input  logic [WIDTH-1:0] regWrData,
  input  logic             regAddr,
  input  logic [WIDTH-1:0] topVal,
  output logic [WIDTH-1:0] cntQ,
  output logic             downQ,
  output logic             flagQ,
  output logic [WIDTH-1:0] rdData,
  output logic             topHit,
  output logic             bottomHit
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (stb.loadCnt) begin
      cntQ <= regWrData;
    end else if (stb.clrCnt) begin
      cntQ <= '0;
    end else if (stb.incCnt) begin
      cntQ <= cntQ + ONE;
    end else if (stb.decCnt) begin
      cntQ <= cntQ - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      downQ <= 1'b0;
    end else if (stb.goDown) begin
      downQ <= 1'b1;
    end else if (stb.goUp) begin
      downQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (stb.setOvf) begin
      flagQ <= 1'b1;
    end else if (stb.clrOvf) begin
      flagQ <= 1'b0;
    end
  end

  assign rdData    = regAddr ? {{(WIDTH-1){1'b0}}, flagQ} : cntQ;
  assign topHit    = (cntQ == topVal);
  assign bottomHit = (cntQ == '0);

endmodule

// File: rtl/updn_timer.sv
module updn_timer
  import updn_tmr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [2:0]       clkSel,
  input  logic [2:0]       waveMode,
  input  logic [WIDTH-1:0] cmpA,
  input  logic             ovfAck,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [WIDTH-1:0] regWrData,
  output logic [WIDTH-1:0] regRdData,
  output logic [WIDTH-1:0] count,
  output logic             countDown,
  output logic             atTop,
  output logic             atBottom,
  output logic             ovfFlag
);

  tmrStrobe_t       stb;
  logic [WIDTH-1:0] cntQ;
  logic [WIDTH-1:0] topVal;
  logic             downQ;
  logic             flagQ;

  updn_tmr_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .tick      (tick),
    .clkSel    (clkSel),
    .waveMode  (waveMode),
    .cmpA      (cmpA),
    .ovfAck    (ovfAck),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .cntQ      (cntQ),
    .downQ     (downQ),
    .topVal    (topVal),
    .stb       (stb)
  );

  updn_tmr_dpath #(.WIDTH(WIDTH)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .regWrData (regWrData),
    .regAddr   (regAddr),
    .topVal    (topVal),
    .cntQ      (cntQ),
    .downQ     (downQ),
    .flagQ     (flagQ),
    .rdData    (regRdData),
    .topHit    (atTop),
    .bottomHit (atBottom)
  );

  assign count     = cntQ;
  assign countDown = downQ;
  assign ovfFlag   = flagQ;

endmodule

// File: rtl/updn_timer_chk.sv
module updn_timer_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic [2:0]       clkSel,
  input logic [2:0]       waveMode,
  input logic             ovfAck,
  input logic             regWrEn,
  input logic             regAddr,
  input logic [WIDTH-1:0] regWrData,
  input logic [WIDTH-1:0] count,
  input logic             countDown,
  input logic             ovfFlag
);

  logic tickOk;
  logic wrCnt;
  logic dualMode;

  assign tickOk   = tick && (clkSel != 3'd0);
  assign wrCnt    = regWrEn && !regAddr;
  assign dualMode = (waveMode == 3'd1) || (waveMode == 3'd5);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tickOk && !wrCnt) |=> $stable(count));

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    wrCnt |=> (count == $past(regWrData)));

  a_r3_normal_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (tickOk && !wrCnt && waveMode == 3'd0 && count == {WIDTH{1'b1}})
      |=> (count == '0 && ovfFlag));

  a_r5_ramp_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (tickOk && !wrCnt && waveMode == 3'd3 && count == {WIDTH{1'b1}})
      |=> (count == '0 && ovfFlag));

  a_r9_ack_clear: assert property (@(posedge clk) disable iff (!rstN)
    (ovfAck && !tickOk) |=> !ovfFlag);

  a_r12_dir_up: assert property (@(posedge clk) disable iff (!rstN)
    (tickOk && !wrCnt && !dualMode) |=> !countDown);

endmodule

bind updn_timer updn_timer_chk #(.WIDTH(WIDTH)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .tick      (tick),
  .clkSel    (clkSel),
  .waveMode  (waveMode),
  .ovfAck    (ovfAck),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .count     (count),
  .countDown (countDown),
  .ovfFlag   (ovfFlag)
);

// File: tb/updn_timer_test.sv
module updn_timer_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] clkSel = 3'd1;
  logic [2:0] waveMode = 3'd0;
  logic [7:0] cmpA = 8'h00;
  logic       ovfAck = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [7:0] count;
  logic       countDown;
  logic       atTop;
  logic       atBottom;
  logic       ovfFlag;

  int  checks = 0;
  int  errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  updn_timer uut (
    .clk(clk), .rstN(rstN), .tick(tick), .clkSel(clkSel), .waveMode(waveMode),
    .cmpA(cmpA), .ovfAck(ovfAck), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .count(count),
    .countDown(countDown), .atTop(atTop), .atBottom(atBottom), .ovfFlag(ovfFlag)
  );

  typedef struct packed {
    logic [2:0] mode;
    logic [7:0] cmp;
    logic [7:0] pre;
    logic [7:0] ticks;
    logic [7:0] expCnt;
    logic       expFlag;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 8'h00, 8'hFD, 8'd2,  8'hFF, 1'b0},  // R3
    '{3'd0, 8'h00, 8'hFD, 8'd3,  8'h00, 1'b1},  // R3
    '{3'd4, 8'h00, 8'hFE, 8'd3,  8'h01, 1'b1},  // R3 unused code
    '{3'd2, 8'h10, 8'h0E, 8'd3,  8'h00, 1'b0},  // R4
    '{3'd2, 8'h10, 8'h0E, 8'd5,  8'h02, 1'b0},  // R4
    '{3'd2, 8'h05, 8'hFE, 8'd3,  8'h01, 1'b1},  // R4 above compare
    '{3'd3, 8'h00, 8'hFE, 8'd2,  8'h00, 1'b1},  // R5
    '{3'd7, 8'h20, 8'h1F, 8'd3,  8'h01, 1'b1},  // R5
    '{3'd7, 8'h20, 8'h1E, 8'd2,  8'h20, 1'b0},  // R5
    '{3'd5, 8'h04, 8'h02, 8'd4,  8'h02, 1'b0},  // R6
    '{3'd5, 8'h04, 8'h02, 8'd7,  8'h01, 1'b1},  // R7
    '{3'd1, 8'h00, 8'hFE, 8'd3,  8'hFD, 1'b0},  // R6
    '{3'd5, 8'h04, 8'h02, 8'd11, 8'h03, 1'b1}   // R6 R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
  endtask

  task automatic wrReg(input logic a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 1'b0;
  endtask

  task automatic runTicks(input int n);
    @(negedge clk) tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 count", count, 8'h00);
    check("R1 flag", ovfFlag, 1'b0);
    check("R1 dir", countDown, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      doReset();
      waveMode = VECS[i].mode;
      cmpA = VECS[i].cmp;
      wrReg(1'b0, VECS[i].pre);
      runTicks(int'(VECS[i].ticks));
      check($sformatf("R3-R7 vec%0d count", i), count, VECS[i].expCnt);
      check($sformatf("R3-R7 vec%0d flag", i), ovfFlag, VECS[i].expFlag);
    end

    // R2 hold with clkSel 0 and with tick low
    doReset(); waveMode = 3'd0;
    wrReg(1'b0, 8'h40);
    clkSel = 3'd0; runTicks(4);
    check("R2 clkSel0 hold", count, 8'h40);
    clkSel = 3'd2;
    repeat (3) @(negedge clk);
    check("R2 tick low hold", count, 8'h40);

    // R8 write vs tick collision at 0xFF
    wrReg(1'b0, 8'hFF);
    @(negedge clk);
    tick = 1'b1; regWrEn = 1'b1; regAddr = 1'b0; regWrData = 8'h55;
    @(negedge clk);
    tick = 1'b0; regWrEn = 1'b0;
    check("R8 write wins", count, 8'h55);
    check("R8 no flag", ovfFlag, 1'b0);

    // R9 flag clears
    wrReg(1'b0, 8'hFF); runTicks(1);
    check("R9 flag set", ovfFlag, 1'b1);
    wrReg(1'b1, 8'hFE);
    check("R9 zero bit no effect", ovfFlag, 1'b1);
    regAddr = 1'b1; #0;
    @(negedge clk);
    check("R10 status read", regRdData, 8'h01);
    regAddr = 1'b0;
    @(negedge clk);
    check("R10 count read", regRdData, count);
    wrReg(1'b1, 8'h01);
    check("R9 w1c", ovfFlag, 1'b0);
    wrReg(1'b0, 8'hFF); runTicks(1);
    @(negedge clk) ovfAck = 1'b1;
    @(negedge clk) ovfAck = 1'b0;
    check("R9 ack clear", ovfFlag, 1'b0);
    wrReg(1'b0, 8'hFF);
    @(negedge clk) begin tick = 1'b1; ovfAck = 1'b1; end
    @(negedge clk) begin tick = 1'b0; ovfAck = 1'b0; end
    check("R9 set beats clear", ovfFlag, 1'b1);

    // R11 top and bottom indications
    check("R11 bottom", atBottom, 1'b1);
    waveMode = 3'd7; cmpA = 8'h30;
    wrReg(1'b0, 8'h30);
    check("R11 top cmp", atTop, 1'b1);
    check("R11 not bottom", atBottom, 1'b0);
    waveMode = 3'd3;
    @(negedge clk);
    check("R11 top max off", atTop, 1'b0);

    // R6 descending indication, then R12 forced up
    doReset(); waveMode = 3'd5; cmpA = 8'h03;
    wrReg(1'b0, 8'h03); runTicks(1);
    check("R6 count after turn", count, 8'h02);
    check("R6 countDown", countDown, 1'b1);
    waveMode = 3'd0; runTicks(1);
    check("R12 count up", count, 8'h03);
    check("R12 dir up", countDown, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule